// File: doc/BRIEF.md
# Character CRT Timing Controller

This block produces the raster timing for a character-based display. A processor programs an eighteen-entry register file through two write strobes: one latches the index of the register to update, the other stores a data byte into the register that index points to. Each stored byte is first trimmed to that register's valid bits. Three cascaded counters run from these settings. The first counts character positions along a line, the second counts scanlines inside a character row, and the third counts character rows in a frame.

The counters move forward once every four system clocks. A clock-enable divider inside the block sets this pace. From the counter values the block drives horizontal sync, vertical sync and display enable. It also gives a 14-bit character memory address and a row address. A 16-bit video RAM byte address is built from those two by placing the row-address bits between the memory-address bits.

Top module: `crt_timing_gen`

## Requirements
- R1: A pulse on `sel_we` latches `wdata` as the register index. A pulse on `data_we` stores `wdata` into register index `0..17`, ANDed with that register's mask. The masks are 0x7F for indices 4, 6, 7 and 10; 0x1F for 9 and 11; 0x3F for 12, 14 and 16; and 0xFF for all others. A data write while the latched index is 18 or above changes no register.
- R2: The counters move only on the single system clock of each group of four that carries the internal step. The first step falls on the fourth rising edge after reset is released.
- R3: On each step the character counter goes up by one while it is below R0. Once it reaches R0 it wraps to 0.
- R4: When the character counter wraps, the scanline counter goes up while below R9 and otherwise wraps to 0. When the scanline counter wraps, the row counter goes up while below R4 and otherwise wraps to 0.
- R5: `hsync` is high while the character counter lies in the inclusive range R2 to R2 plus R3[3:0]. A zero width in R3[3:0] gives no pulse.
- R6: `vsync` is high while the row counter lies in the inclusive range R7 to R7 plus R3[7:4]. A zero width in R3[7:4] gives no pulse.
- R7: `de` is high only while the character counter is below R1 and the row counter is below R6.
- R8: `ma` equals (start + row × R1 + character) modulo 2^14. `ra` equals the scanline counter.
- R9: `vaddr` equals {ma[13:12], ra[2:0], ma[9:0], 1'b0}.
- R10: The start address is {R12[5:0], R13}. It is sampled on the step that wraps all three counters together, and it is 0 after reset.
- R11: A synchronous active-high reset clears all counters, registers and the latched index. Every output is then 0 until the registers are programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Latch `wdata` as register index |
| data_we | input | 1 | Store `wdata` into the indexed register |
| wdata | input | 8 | Write data byte |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| ma | output | 14 | Character memory address |
| ra | output | 5 | Row (scanline) address |
| vaddr | output | 16 | Video RAM byte address |

## Verification
The bench builds the block with its default parameters: eighteen registers and a divide-by-four step. It uses small register values so that a full frame spans only about a thousand clocks. Because of this, whole frames can be run, which covers the start-address sample at the frame wrap, sync pulses that span several rows, and the cascade of all three counters. A second programming pass makes both sync widths zero or narrow and shrinks the frame, covering a scanline total of zero and the absence of a vertical pulse. A write to an index beyond the file and byte values above the masks also go through the per-cycle comparison.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int CW = 8;

    typedef struct packed {
        logic [CW-1:0] hcc;
        logic [CW-1:0] vlc;
        logic [CW-1:0] vcc;
    } crtc_cnt_t;

    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            4, 6, 7, 10: return 8'h7F;
            9, 11:       return 8'h1F;
            12, 14, 16:  return 8'h3F;
            default:     return 8'hFF;
        endcase
    endfunction

    function automatic logic in_window(input logic [7:0] pos,
                                       input logic [7:0] first,
                                       input logic [3:0] width);
        logic [8:0] last;
        last = {1'b0, first} + {5'd0, width};
        return (width != 4'd0) && (pos >= first) && ({1'b0, pos} <= last);
    endfunction

    function automatic logic [15:0] pack_vaddr(input logic [13:0] ma,
                                               input logic [4:0] ra);
        return {ma[13:12], ra[2:0], ma[9:0], 1'b0};
    endfunction

endpackage

// File: rtl/crtc_step.sv
module crtc_step #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/crtc_regs.sv
module crtc_regs #(
    parameter int NUM_REGS = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel_we,
    input  logic                     data_we,
    input  logic [7:0]               wdata,
    output logic [NUM_REGS-1:0][7:0] regs
);
    import crtc_pkg::*;

    logic [7:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else if (sel_we) sel_q <= wdata;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (data_we && sel_q == 8'(g))
                regs[g] <= wdata & reg_mask(g);
        end
    end

    a_r1_ignore_high_index: assert property (@(posedge clk) disable iff (rst)
        (data_we && sel_q >= 8'(NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/crtc_count.sv
module crtc_count (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [7:0]          h_total,
    input  logic [7:0]          sl_total,
    input  logic [7:0]          row_total,
    output crtc_pkg::crtc_cnt_t cnt,
    output logic                frame_wrap
);
    logic h_end, sl_end, row_end;

    assign h_end      = cnt.hcc >= h_total;
    assign sl_end     = cnt.vlc >= sl_total;
    assign row_end    = cnt.vcc >= row_total;
    assign frame_wrap = tick && h_end && sl_end && row_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (!h_end) begin
                cnt.hcc <= cnt.hcc + 1'b1;
            end else begin
                cnt.hcc <= '0;
                if (!sl_end) begin
                    cnt.vlc <= cnt.vlc + 1'b1;
                end else begin
                    cnt.vlc <= '0;
                    cnt.vcc <= row_end ? '0 : cnt.vcc + 1'b1;
                end
            end
        end
    end

    a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    a_r3_char_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt.hcc >= h_total) |=> cnt.hcc == '0);
    a_r4_scanline_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt.hcc < h_total) |=> $stable(cnt.vlc) && $stable(cnt.vcc));
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
    parameter int NUM_REGS = 18,
    parameter int DIV      = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_we,
    input  logic        data_we,
    input  logic [7:0]  wdata,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic [13:0] ma,
    output logic [4:0]  ra,
    output logic [15:0] vaddr
);
    import crtc_pkg::*;

    logic [NUM_REGS-1:0][7:0] regs;
    logic                     tick;
    logic                     frame_wrap;
    crtc_cnt_t                cnt;
    logic [13:0]              start_q;
    logic [15:0]              row_base;
    logic [15:0]              lin_addr;

    crtc_step #(.DIV(DIV)) u_step (.clk(clk), .rst(rst), .tick(tick));

    crtc_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .sel_we(sel_we), .data_we(data_we),
        .wdata(wdata), .regs(regs));

    crtc_count u_count (
        .clk(clk), .rst(rst), .tick(tick),
        .h_total(regs[0]), .sl_total(regs[9]), .row_total(regs[4]),
        .cnt(cnt), .frame_wrap(frame_wrap));

    always_ff @(posedge clk) begin
        if (rst)             start_q <= '0;
        else if (frame_wrap) start_q <= {regs[12][5:0], regs[13]};
    end

    assign row_base = cnt.vcc * regs[1];
    assign lin_addr = {2'b00, start_q} + row_base + {8'd0, cnt.hcc};

    assign hsync = in_window(cnt.hcc, regs[2], regs[3][3:0]);
    assign vsync = in_window(cnt.vcc, regs[7], regs[3][7:4]);
    assign de    = (cnt.hcc < regs[1]) && (cnt.vcc < regs[6]);
    assign ma    = lin_addr[13:0];
    assign ra    = cnt.vlc[4:0];
    assign vaddr = pack_vaddr(ma, ra);

    a_r5_zero_width_quiet: assert property (@(posedge clk) disable iff (rst)
        (regs[3][3:0] == 4'd0) |-> !hsync);
    a_r10_start_held: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> $stable(start_q));
    a_r7_de_in_row: assert property (@(posedge clk) disable iff (rst)
        de |-> (cnt.vcc < regs[6]));
endmodule

// File: tb/sim_crt_timing_gen.sv
module sim_crt_timing_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic        data_we = 1'b0;
    logic [7:0]  wdata = '0;
    logic        hsync, vsync, de;
    logic [13:0] ma;
    logic [4:0]  ra;
    logic [15:0] vaddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    crt_timing_gen u0 (.clk(clk), .rst(rst), .sel_we(sel_we), .data_we(data_we),
        .wdata(wdata), .hsync(hsync), .vsync(vsync), .de(de), .ma(ma),
        .ra(ra), .vaddr(vaddr));

    // Behavioural reference model
    int m_reg[18];
    int m_sel, m_div, m_h, m_sl, m_row, m_start;

    function automatic int mask_of(int i);
        if (i == 4 || i == 6 || i == 7 || i == 10) return 'h7F;
        if (i == 9 || i == 11) return 'h1F;
        if (i == 12 || i == 14 || i == 16) return 'h3F;
        return 'hFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_sel = 0; m_div = 0; m_h = 0; m_sl = 0; m_row = 0; m_start = 0;
        end else begin
            if (m_div == 3) begin
                if (m_h < m_reg[0]) m_h++;
                else begin
                    m_h = 0;
                    if (m_sl < m_reg[9]) m_sl++;
                    else begin
                        m_sl = 0;
                        if (m_row < m_reg[4]) m_row++;
                        else begin
                            m_row = 0;
                            m_start = m_reg[12] * 256 + m_reg[13];
                        end
                    end
                end
            end
            m_div = (m_div + 1) % 4;
            if (data_we && m_sel < 18) m_reg[m_sel] = wdata & mask_of(m_sel);
            if (sel_we) m_sel = wdata;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit win(int pos, int first, int w);
        return (w != 0) && pos >= first && pos <= first + w;
    endfunction

    bit compare_on = 0;
    bit seen_vs = 0, seen_hs = 0, seen_start = 0;

    always @(negedge clk) begin
        if (compare_on) begin
            int exp_ma;
            exp_ma = (m_start + m_row * m_reg[1] + m_h) % 16384;
            check("R5 hsync", hsync, win(m_h, m_reg[2], m_reg[3] % 16));
            check("R6 vsync", vsync, win(m_row, m_reg[7], m_reg[3] / 16));
            check("R7 de", de, (m_h < m_reg[1]) && (m_row < m_reg[6]));
            // R2 R3 R4 R10 all feed the address comparison
            check("R8 ma", ma, exp_ma);
            check("R8 ra", ra, m_sl % 32);
            check("R9 vaddr", vaddr, ((exp_ma >> 12) % 4) * 16384 + (m_sl % 8) * 2048
                                     + (exp_ma % 1024) * 2);
            if (vsync) seen_vs = 1;
            if (hsync) seen_hs = 1;
            if (ma == 14'h3F10) seen_start = 1;
        end
    end

    task automatic wr(int idx, int val);
        @(negedge clk); #1;
        sel_we = 1; wdata = 8'(idx);
        @(negedge clk); #1;
        sel_we = 0; data_we = 1; wdata = 8'(val);
        @(negedge clk); #1;
        data_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R11: reset state
        check("R11 hsync", hsync, 0);
        check("R11 vsync", vsync, 0);
        check("R11 de", de, 0);
        check("R11 vaddr", vaddr, 0);
        compare_on = 1;
        // pattern 1; masks exercised on R9, R12 (R1)
        wr(0, 15); wr(1, 10); wr(2, 11); wr(3, 'h32); wr(4, 5);
        wr(6, 4); wr(7, 4); wr(9, 'hE2); wr(12, 'hFF); wr(13, 'h10);
        wr(30, 'h77); // R1: ignored index
        repeat (3000) @(negedge clk);
        check("R6 vsync seen", seen_vs, 1);
        check("R5 hsync seen", seen_hs, 1);
        check("R1 R10 masked start", seen_start, 1);
        // pattern 2: no vsync width, single-scanline rows
        seen_vs = 0;
        wr(3, 'h05); wr(0, 7); wr(9, 0); wr(4, 3); wr(12, 2); wr(13, 'h80);
        wr(25, 'h01); // R1: ignored index
        repeat (1500) @(negedge clk);
        check("R6 zero width no vsync", seen_vs, 0);
        // reset mid-run
        #1 rst = 1;
        @(negedge clk); #1 rst = 0;
        @(negedge clk);
        check("R11 ma after reset", ma, 0);
        check("R11 hsync after reset", hsync, 0);
        repeat (40) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule